// File: doc/BRIEF.md
# Time-Shared Adder Codeword Builder

This block protects a run of P additions with one shared systematic linear block code. A single W-bit adder is reused for P consecutive operations. Each accepted operation is two W-bit operands and a carry-in. Its (W+1)-bit result, the sum bits with the carry-out on top, fills the next slot of the information field. The operands are also captured into a P-entry register set. Once the P-th operation is in, a check field of M bits is formed. It is a GF(2) product of the generator's check columns with results that are recomputed from all P captured operand sets, not taken from the shared adder. The full codeword is then presented with a one-cycle valid pulse.

Operations enter on a valid/ready handshake. Ready drops only in the cycle in which the codeword is presented. A flush input throws away a partly filled group. P, the operand width, the check width and the generator's check columns are elaboration-time parameters. With the defaults (W=6, P=2, M=41) a 14-bit information field becomes a 55-bit codeword. With P=4 and M=100 a 28-bit field becomes a 128-bit codeword.

Top module: `stq_codeword_seq`

## Requirements
- R1: After reset, cw_valid is 0 and in_ready is 1.
- R2: In a presented codeword, bits [i*(W+1)+W : i*(W+1)] hold in_a+in_b+in_cin of the i-th operation accepted in the group, counting from 0. The carry-out is the top bit of each slot.
- R3: Check bit j (codeword bit K+j, K=P*(W+1)) is the XOR of the information bits k for which GPAR[j*K+k] is 1. It is recomputed from the captured operands.
- R4: cw_valid rises in the cycle after the P-th operation of a group is accepted and stays high for exactly one cycle.
- R5: in_ready is 0 exactly while cw_valid is 1. An operation offered in that cycle is not accepted and does not take a slot.
- R6: A flush discards the operations already accepted in the current group. The next codeword is built from the P operations accepted after the flush, and no codeword is presented for the discarded part.
- R7: Cycles with in_valid low do not advance the group. Operations separated by idle cycles still fill consecutive slots.
- R8: An operation offered in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard the partial group |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_cin | input | 1 | Carry-in |
| cw_valid | output | 1 | Codeword present, one cycle |
| cw_data | output | P*(W+1)+M | Information field (low) then check field (high) |

## Verification
A slot counter that is wrong shows as results landing in the wrong slot, or as a codeword presented one operation early or late. Either way it is visible on the first codeword after the fault. A stale or misaligned operand register breaks the agreement between the check field and the information field in that same codeword, because the two are produced by separate adders. The sweep covers every operand pair in both slots, so a single wrong result bit or check column is exposed within one group.

// File: rtl/stq_codeword_seq.sv
module stq_codeword_seq #(
  parameter int W = 6,
  parameter int P = 2,
  parameter int M = 41,
  parameter logic [M*P*(W+1)-1:0] GPAR =
    (M*P*(W+1))'({((M*P*(W+1)+63)/64){64'h9E37_79B9_7F4A_7C15}})
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [W-1:0]             in_a,
  input  logic [W-1:0]             in_b,
  input  logic                     in_cin,
  output logic                     cw_valid,
  output logic [P*(W+1)+M-1:0]     cw_data
);
  localparam int RB = W + 1;
  localparam int K  = P * RB;
  localparam int CW = (P > 1) ? $clog2(P) : 1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  a_q [P];
  logic [W-1:0]  b_q [P];
  logic          c_q [P];
  logic [K-1:0]  info_q;
  logic [K-1:0]  re_info;
  logic [M-1:0]  parity;
  logic          valid_q;
  logic [RB-1:0] sum_now;

  wire accept = in_valid && in_ready && !flush;
  wire last   = (cnt == CW'(P-1));

  assign in_ready = !valid_q;
  assign cw_valid = valid_q;
  assign sum_now  = {1'b0, in_a} + {1'b0, in_b} + RB'(in_cin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= accept && last;
      if (flush)       cnt <= '0;
      else if (accept) cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      a_q[cnt] <= in_a;
      b_q[cnt] <= in_b;
      c_q[cnt] <= in_cin;
      info_q[cnt*RB +: RB] <= sum_now;
    end
  end

  for (genvar g = 0; g < P; g++) begin : g_reenc
    assign re_info[g*RB +: RB] = {1'b0, a_q[g]} + {1'b0, b_q[g]} + RB'(c_q[g]);
  end

  for (genvar j = 0; j < M; j++) begin : g_par
    assign parity[j] = ^(re_info & GPAR[j*K +: K]);
  end

  assign cw_data = {parity, info_q};
endmodule

module stq_codeword_seq_chk #(
  parameter int K = 14,
  parameter int M = 41,
  parameter logic [M*K-1:0] GPAR = '0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush,
  input logic           in_ready,
  input logic           cw_valid,
  input logic [K+M-1:0] cw_data
);
  logic [M-1:0] exp_par;
  always_comb
    for (int j = 0; j < M; j++)
      exp_par[j] = ^(cw_data[K-1:0] & GPAR[j*K +: K]);

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!cw_valid && in_ready));
  p_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> (cw_data[K+M-1:K] == exp_par));
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |=> !cw_valid);
  p_ready_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> !in_ready);
  p_ready_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cw_valid |-> in_ready);
  p_flush_no_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !cw_valid);
endmodule

bind stq_codeword_seq stq_codeword_seq_chk #(.K(K), .M(M), .GPAR(GPAR)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .cw_valid(cw_valid), .cw_data(cw_data)
);

// File: tb/stq_codeword_seq_tb.sv
module stq_codeword_seq_tb_top;
  localparam int W = 6, P = 2, M = 41, K = 14, N = 55;
  localparam logic [M*K-1:0] GB = (M*K)'({9{64'hC6A4_A793_5BD1_E995}});

  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, in_cin = 0;
  logic [W-1:0] in_a = 0, in_b = 0;
  logic in_ready, cw_valid;
  logic [N-1:0] cw_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stq_codeword_seq #(.W(W), .P(P), .M(M), .GPAR(GB)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_a(in_a), .in_b(in_b), .in_cin(in_cin),
    .cw_valid(cw_valid), .cw_data(cw_data));

  function automatic logic [6:0] res(input logic [5:0] a, input logic [5:0] b, input logic c);
    return 7'(a) + 7'(b) + 7'(c);
  endfunction

  function automatic logic [N-1:0] expect_cw(input logic [13:0] info);
    logic [M-1:0] p;
    for (int j = 0; j < M; j++) begin
      p[j] = 1'b0;
      for (int k = 0; k < K; k++) if (GB[j*K+k]) p[j] = p[j] ^ info[k];
    end
    return {p, info};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit f, input logic [5:0] a, input logic [5:0] b, input logic c);
    @(negedge clk);
    in_valid = v; flush = f; in_a = a; in_b = b; in_cin = c;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic check_cw(input logic [13:0] info, input string tag);
    logic [N-1:0] e;
    e = expect_cw(info);
    chk(cw_valid === 1'b1, {tag, " R4 valid"}, 64'(cw_valid), 1);
    chk(in_ready === 1'b0, {tag, " R5 ready low"}, 64'(in_ready), 0);
    chk(cw_data[K-1:0] === e[K-1:0], {tag, " R2 info"}, 64'(cw_data[K-1:0]), 64'(e[K-1:0]));
    chk(cw_data === e, {tag, " R3 parity"}, 64'(cw_data), 64'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] a1, b1;
    logic c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cw_valid === 0, "R1 reset valid", 64'(cw_valid), 0);
    chk(in_ready === 1, "R1 reset ready", 64'(in_ready), 1);

    // R2 R3 R4 sweep of every operand pair in both slots
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        c0 = 1'(i ^ j); a1 = 6'(j); b1 = 6'(~i); c1 = 1'(i >> 1);
        drive(1, 0, 6'(i), 6'(j), c0);
        drive(1, 0, a1, b1, c1);
        drive(0, 0, 0, 0, 0);
        check_cw({res(a1, b1, c1), res(6'(i), 6'(j), c0)}, "sweep");
        idle();
        chk(cw_valid === 0, "R4 single pulse", 64'(cw_valid), 0);
      end
    end

    // R7 idle gaps between operations
    drive(1, 0, 6'd63, 6'd63, 1);
    idle(); idle();
    chk(cw_valid === 0, "R7 no early codeword", 64'(cw_valid), 0);
    drive(1, 0, 6'd5, 6'd9, 0);
    idle();
    check_cw({res(5, 9, 0), res(63, 63, 1)}, "R7 gaps");
    idle();

    // R5 offer held through emission cycle
    drive(1, 0, 6'd1, 6'd2, 0);
    drive(1, 0, 6'd3, 6'd4, 1);
    drive(1, 0, 6'd40, 6'd30, 1);
    check_cw({res(3, 4, 1), res(1, 2, 0)}, "R5 first");
    drive(1, 0, 6'd40, 6'd30, 1);
    drive(1, 0, 6'd17, 6'd0, 0);
    drive(0, 0, 0, 0, 0);
    check_cw({res(17, 0, 0), res(40, 30, 1)}, "R5 offer in emission ignored");
    idle();

    // R6 flush discards partial group
    drive(1, 0, 6'd11, 6'd22, 1);
    drive(0, 1, 0, 0, 0);
    drive(1, 0, 6'd33, 6'd44, 0);
    chk(cw_valid === 0, "R6 no codeword after flush", 64'(cw_valid), 0);
    drive(1, 0, 6'd50, 6'd60, 1);
    drive(0, 0, 0, 0, 0);
    check_cw({res(50, 60, 1), res(33, 44, 0)}, "R6 flush");
    idle();

    // R8 operation coincident with flush is dropped
    drive(1, 1, 6'd7, 6'd7, 1);
    drive(1, 0, 6'd8, 6'd2, 0);
    drive(1, 0, 6'd9, 6'd61, 1);
    drive(0, 0, 0, 0, 0);
    check_cw({res(9, 61, 1), res(8, 2, 0)}, "R8 flush with valid");
    idle();
    chk(cw_valid === 0, "R4 pulse ends", 64'(cw_valid), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule